// File: doc/BRIEF.md
# Flagged Combinational Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It takes two operands, `opnd_x` and `opnd_y`, and a 4-bit operation select. It returns a result word and four status flags: zero, negative, carry and overflow. It has no clock, no reset and no stored state, so its outputs follow its inputs alone. A host pipeline samples the outputs in whatever register stage it places around the block.

Twelve of the sixteen select codes name operations:
- arithmetic: add, subtract, increment and decrement;
- bitwise logic: AND, OR, XOR and invert;
- one-place logical shifts, left and right;
- an equality mask and a pass-through.

Each operation has its own rule for carry and overflow. The zero and negative flags always describe the result word. The four remaining select codes give an all-zero result with carry and overflow cleared.

Top module: `flag_alu`

## Requirements
- R1: The select encoding is 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 invert, 6 shift left, 7 shift right, 8 increment, 9 decrement, 10 equality mask and 11 pass-through. The flags are read as z_flag (zero), n_flag (negative), c_flag (carry) and v_flag (overflow).
- R2: Add (select 0) returns x+y modulo 256. Carry is bit 8 of the 9-bit unsigned sum. Overflow is set when x and y have equal sign bits and the result's sign bit differs from x's.
- R3: Subtract (select 1) returns x−y modulo 256. Carry is bit 8 of the 9-bit unsigned difference, so it is 1 on a borrow and is not inverted. Overflow is set when x and y have different sign bits and the result's sign bit differs from x's.
- R4: AND, OR and XOR (selects 2, 3 and 4) return the bitwise combination of x and y, with carry and overflow at 0.
- R5: Invert (select 5) returns ~x and pass-through (select 11) returns x. For both, the value of y has no effect on any output, and carry and overflow are 0.
- R6: Shift left (select 6) returns x moved up one place with a 0 in bit 0, and carry takes the old x[7]. Shift right (select 7) returns x moved down one place with a 0 in bit 7, and carry takes the old x[0]. Overflow is 0 for both.
- R7: Increment (select 8) returns x+1, with carry set only on the wrap from 0xFF. Decrement (select 9) returns x−1, with carry set only on the borrow from 0x00. Overflow is 0 for both.
- R8: The equality mask (select 10) returns 0x00 when x equals y and 0xFF otherwise, with carry and overflow at 0.
- R9: Selects 12 to 15 return 0x00 with carry and overflow at 0.
- R10: For every select, z_flag is 1 exactly when the result is 0x00, and n_flag equals result bit 7.
- R11: The outputs depend only on the present inputs. The same inputs give the same outputs whatever operation was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | 8 | First operand |
| opnd_y | input | 8 | Second operand (not used by unary operations) |
| op_sel | input | 4 | Operation select |
| res | output | 8 | Result word |
| z_flag | output | 1 | Result is zero |
| n_flag | output | 1 | Result bit 7 |
| c_flag | output | 1 | Carry, borrow or shifted-out bit |
| v_flag | output | 1 | Signed overflow |

## Verification
The embedded checks are immediate and evaluated on every input change. They therefore assume the operands and the select are fully known values; an unknown select could take neither branch of a guard. The stimulus always drives defined values, including on y during unary operations, where y is deliberately swapped between extremes to show it has no effect. The bench changes inputs only just after a rising edge of its pacing clock and samples on the falling edge, so every comparison sees settled outputs.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_SUM  = 4'd0,
        OP_DIFF = 4'd1,
        OP_BAND = 4'd2,
        OP_BOR  = 4'd3,
        OP_BXOR = 4'd4,
        OP_INV  = 4'd5,
        OP_LSL  = 4'd6,
        OP_LSR  = 4'd7,
        OP_INCR = 4'd8,
        OP_DECR = 4'd9,
        OP_EQM  = 4'd10,
        OP_THRU = 4'd11
    } op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } side_t;

    function automatic logic is_arith(input logic [OPW-1:0] op);
        return (op == OP_SUM) || (op == OP_DIFF) || (op == OP_INCR) || (op == OP_DECR);
    endfunction

    function automatic logic is_resv(input logic [OPW-1:0] op);
        return op > OP_THRU;
    endfunction

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
    import flag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic [OPW-1:0] op,
    output logic [W-1:0]   r,
    output side_t          s
);
    localparam int MSB = W - 1;
    localparam logic [W:0] ONE = (W+1)'(1);

    logic       use_y;
    logic       do_sub;
    logic [W:0] rhs;
    logic [W:0] wide;

    always_comb begin
        use_y  = (op == OP_SUM) || (op == OP_DIFF);
        do_sub = (op == OP_DIFF) || (op == OP_DECR);
        rhs    = use_y ? {1'b0, y} : ONE;
        wide   = do_sub ? ({1'b0, x} - rhs) : ({1'b0, x} + rhs);
        r       = wide[MSB:0];
        s.carry = wide[W];
        s.ovf   = 1'b0;
        if (op == OP_SUM)
            s.ovf = (x[MSB] == y[MSB]) && (r[MSB] != x[MSB]);
        else if (op == OP_DIFF)
            s.ovf = (x[MSB] != y[MSB]) && (r[MSB] != x[MSB]);
    end

    always_comb begin
        if (op == OP_INCR && s.carry)
            p_inc_wrap_r7: assert (r == '0);
        if (op == OP_DECR && s.carry)
            p_dec_wrap_r7: assert (&r);
        if (op == OP_SUM && s.ovf)
            p_add_ovf_sign_r2: assert (x[MSB] == y[MSB]);
        if (op == OP_DIFF && s.ovf)
            p_sub_ovf_sign_r3: assert (x[MSB] != y[MSB]);
    end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic [OPW-1:0] op,
    output logic [W-1:0]   r,
    output side_t          s
);
    localparam int MSB = W - 1;

    always_comb begin
        r       = '0;
        s.carry = 1'b0;
        s.ovf   = 1'b0;
        case (op)
            OP_BAND: r = x & y;
            OP_BOR:  r = x | y;
            OP_BXOR: r = x ^ y;
            OP_INV:  r = ~x;
            OP_LSL: begin
                r       = {x[MSB-1:0], 1'b0};
                s.carry = x[MSB];
            end
            OP_LSR: begin
                r       = {1'b0, x[MSB:1]};
                s.carry = x[0];
            end
            OP_EQM:  r = (x == y) ? '0 : '1;
            OP_THRU: r = x;
            default: r = '0;
        endcase
    end

    always_comb begin
        if (op == OP_LSL)
            p_lsl_fill_r6: assert (r[0] == 1'b0);
        if (op == OP_LSR)
            p_lsr_fill_r6: assert (r[MSB] == 1'b0);
        if (op != OP_LSL && op != OP_LSR)
            p_logic_noflag_r4: assert (!s.carry && !s.ovf);
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   opnd_x,
    input  logic [W-1:0]   opnd_y,
    input  logic [OPW-1:0] op_sel,
    output logic [W-1:0]   res,
    output logic           z_flag,
    output logic           n_flag,
    output logic           c_flag,
    output logic           v_flag
);
    localparam int MSB = W - 1;

    logic [W-1:0] arith_r;
    logic [W-1:0] logic_r;
    side_t        arith_s;
    side_t        logic_s;
    side_t        sel_s;

    flag_alu_arith #(.W(W)) u_arith (
        .x(opnd_x), .y(opnd_y), .op(op_sel), .r(arith_r), .s(arith_s)
    );

    flag_alu_logic #(.W(W)) u_logic (
        .x(opnd_x), .y(opnd_y), .op(op_sel), .r(logic_r), .s(logic_s)
    );

    always_comb begin
        if (is_resv(op_sel)) begin
            res   = '0;
            sel_s = '0;
        end else if (is_arith(op_sel)) begin
            res   = arith_r;
            sel_s = arith_s;
        end else begin
            res   = logic_r;
            sel_s = logic_s;
        end
        c_flag = sel_s.carry;
        v_flag = sel_s.ovf;
        z_flag = (res == '0);
        n_flag = res[MSB];
    end

    always_comb begin
        if (is_resv(op_sel))
            p_resv_zero_r9: assert (res == '0 && !c_flag && !v_flag);
        if (op_sel == OP_EQM)
            p_mask_shape_r8: assert ((res == '0) || (&res));
        if (op_sel == OP_INV || op_sel == OP_THRU)
            p_unary_noflag_r5: assert (!c_flag && !v_flag);
        p_zn_excl_r10: assert (!(z_flag && n_flag));
    end

endmodule

// File: tb/sim_flag_alu.sv
`timescale 1ns / 1ps
module sim_flag_alu;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [7:0] x, y, res;
    logic [3:0] op;
    logic       z, n, c, v;
    int         nchk = 0;
    int         nbad = 0;
    bit         done = 1'b0;

    flag_alu u0 (
        .opnd_x(x), .opnd_y(y), .op_sel(op), .res(res),
        .z_flag(z), .n_flag(n), .c_flag(c), .v_flag(v)
    );

    // {op, x, y, result, z n c v}
    localparam logic [31:0] VEC [0:31] = '{
        32'h0_12_34_46_0, 32'h0_FF_01_00_A, 32'h0_7F_01_80_5, 32'h0_80_80_00_B,
        32'h1_34_34_00_8, 32'h1_00_01_FF_6, 32'h1_80_01_7F_1, 32'h1_12_34_DE_6,
        32'h2_AB_0F_0B_0, 32'h2_AA_55_00_8, 32'h3_0F_F0_FF_4, 32'h4_5A_5A_00_8,
        32'h4_AA_55_FF_4, 32'h5_A5_33_5A_0, 32'h5_FF_33_00_8, 32'h6_80_33_00_A,
        32'h6_A5_33_4A_2, 32'h7_01_33_00_A, 32'h7_A5_33_52_2, 32'h7_02_33_01_0,
        32'h8_FF_33_00_A, 32'h8_7F_33_80_4, 32'h9_00_33_FF_6, 32'h9_80_33_7F_0,
        32'hA_55_55_00_8, 32'hA_55_AA_FF_4, 32'hB_5A_33_5A_0, 32'hB_80_33_80_4,
        32'hC_FF_FF_00_8, 32'hD_FF_FF_00_8, 32'hE_80_01_00_8, 32'hF_FF_FF_00_8
    };

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2, 4'd3, 4'd4: return "R4";
            4'd5, 4'd11: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8, 4'd9: return "R7";
            4'd10: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [11:0] model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
        logic [8:0] t;
        logic [7:0] r;
        logic       cy, ov;
        t = '0; r = '0; cy = 1'b0; ov = 1'b0;
        case (o)
            4'd0: begin t = a + b; r = t[7:0]; cy = t[8]; ov = (a[7] == b[7]) && (r[7] != a[7]); end
            4'd1: begin t = {1'b0, a} - {1'b0, b}; r = t[7:0]; cy = t[8]; ov = (a[7] != b[7]) && (r[7] != a[7]); end
            4'd2: r = a & b;
            4'd3: r = a | b;
            4'd4: r = a ^ b;
            4'd5: r = ~a;
            4'd6: begin r = a << 1; cy = a[7]; end
            4'd7: begin r = a >> 1; cy = a[0]; end
            4'd8: begin r = a + 8'd1; cy = (a == 8'hFF); end
            4'd9: begin r = a - 8'd1; cy = (a == 8'h00); end
            4'd10: r = (a == b) ? 8'h00 : 8'hFF;
            4'd11: r = a;
            default: r = 8'h00;
        endcase
        return {r, r == 8'h00, r[7], cy, ov};
    endfunction

    task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic [11:0] exp, input string rq);
        @(posedge clk);
        #0.5 op = o; x = a; y = b;
        @(negedge clk);
        nchk++;
        if ({res, z, n, c, v} !== exp) begin
            nbad++;
            $display("FAIL %s op=%h x=%h y=%h: got %h/%b%b%b%b expected %h/%b",
                     rq, o, a, b, res, z, n, c, v, exp[11:4], exp[3:0]);
        end
    endtask

    initial begin
        op = 4'd0; x = 8'h00; y = 8'h00;
        // reset-time state: add of zeros, zero flag only (R10)
        apply(4'd0, 8'h00, 8'h00, {8'h00, 4'b1000}, "R10");
        // R1 encoding walked by the table
        for (int i = 0; i < 32; i++)
            apply(VEC[i][31:28], VEC[i][27:20], VEC[i][19:12], VEC[i][11:0], tag(VEC[i][31:28]));
        // R5: y swapped between extremes must not change unary outputs
        apply(4'd5, 8'hA5, 8'h00, {8'h5A, 4'b0000}, "R5");
        apply(4'd5, 8'hA5, 8'hFF, {8'h5A, 4'b0000}, "R5");
        apply(4'd11, 8'h81, 8'h00, {8'h81, 4'b0100}, "R5");
        apply(4'd11, 8'h81, 8'hFF, {8'h81, 4'b0100}, "R5");
        // R11: same inputs after different prior operations
        apply(4'd6, 8'h80, 8'h00, {8'h00, 4'b1010}, "R6");
        apply(4'd0, 8'h12, 8'h34, {8'h46, 4'b0000}, "R11");
        apply(4'd8, 8'hFF, 8'h00, {8'h00, 4'b1010}, "R7");
        apply(4'd0, 8'h12, 8'h34, {8'h46, 4'b0000}, "R11");
        // R10 flags across broad stimulus
        for (int k = 0; k < 400; k++) begin
            logic [3:0] o;
            logic [7:0] a, b;
            o = 4'($urandom);
            a = 8'($urandom);
            b = 8'($urandom);
            apply(o, a, b, model(o, a, b), "R10");
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

endmodule